// File: doc/BRIEF.md
# APB Slave Timeout Terminator

This block sits on the master side of an APB bus that has one master and several slaves. It counts the access-phase cycles of every transfer. If the addressed slave has not raised its ready within a programmable number of clock cycles, the block ends the transfer itself. For one cycle it returns ready with an error flag and all-zero read data, which frees the bus for the next access. At the same moment it keeps the offending address and raises a pending flag, which drives a level-high interrupt when it is enabled. While no timeout is being forced, the slave's response passes straight through to the master.

Software reaches the block through its own small APB register port, which completes every access with no wait states. Through this port software reads and writes a status/control word, reads the captured fault address, and sets the cycle limit. Writing the pending bit clears it, or sets it to test an interrupt without a real fault.

Top module: `apb_tmo_term`

## Requirements
- R1: After reset the pending flag is 0, the enable flag is 0, the cycle limit reads 0x400, the captured address reads 0 and `irq` is low.
- R2: The register port decodes three 32-bit words with no wait states: offset 0x0 status/control (bit 0 pending, bit 1 enable), offset 0x4 captured fault address (zero-extended), offset 0x8 cycle limit. Any other offset reads 0 and ignores writes.
- R3: A value written to the cycle limit that is below 0x3FF is stored as 0x3FF. Any other value is stored unchanged.
- R4: With cycle limit T, a slave that raises ready on access cycle r, where 1 <= r <= T, completes the transfer on cycle r. Its ready, error and read data reach the master unchanged.
- R5: If the slave is still not ready on access cycle T, the block drives ready=1, error=1 and read data=0 to the master in that cycle.
- R6: A forced completion sets the pending flag at the next clock edge. When the pending flag was clear, it also captures the transfer's address.
- R7: While the pending flag is set, a further forced completion leaves the captured address unchanged.
- R8: `irq` is high exactly while the pending flag and the enable flag are both 1.
- R9: Writing the status word loads the pending flag from bit 0 and the enable flag from bit 1. A 0 clears the pending flag and a 1 sets it, which injects an interrupt. A forced completion in the same cycle wins over a clear.
- R10: The cycle count restarts for every transfer, so back-to-back transfers each get the full window of T access cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| mon_psel | input | 1 | Select of the monitored transfer |
| mon_penable | input | 1 | Enable (access phase) of the monitored transfer |
| mon_paddr | input | AW | Address of the monitored transfer |
| slv_pready | input | 1 | Ready returned by the slaves |
| slv_pslverr | input | 1 | Error returned by the slaves |
| slv_prdata | input | DW | Read data returned by the slaves |
| mst_pready | output | 1 | Ready delivered to the master |
| mst_pslverr | output | 1 | Error delivered to the master |
| mst_prdata | output | DW | Read data delivered to the master |
| cfg_psel | input | 1 | Register port select |
| cfg_penable | input | 1 | Register port enable |
| cfg_pwrite | input | 1 | Register port write strobe |
| cfg_paddr | input | CAW | Register port byte offset |
| cfg_pwdata | input | DW | Register port write data |
| cfg_prdata | output | DW | Register port read data |
| irq | output | 1 | Level-high fault interrupt |

## Verification
The monitored transfers use slaves that answer on the first access cycle, exactly on cycle T, one cycle after T, or never. These cases separate plain pass-through from a forced completion and place the boundary on the right cycle. Back-to-back transfers that each answer on cycle T show whether the count restarts per transfer. Timeouts that repeat while a fault is pending show whether the first address is kept. Random addresses, ready positions and status writes (clear, enable, inject) are compared against a model of the flags and the captured address, which catches errors in the order of set, clear and capture.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_LIM  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Raise a written limit to the floor value when it falls below it.
  function automatic logic [31:0] clamp_limit(input logic [31:0] v,
                                              input logic [31:0] floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  // Map a zero-extended byte offset onto a register word.
  function automatic reg_sel_e decode_off(input logic [31:0] off);
    case (off)
      32'h0:   return SEL_STAT;
      32'h4:   return SEL_ADDR;
      32'h8:   return SEL_LIM;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tmo_watch.sv
module tmo_watch #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          rdy,
  input  logic [TW-1:0] limit,
  output logic          fire
);
  logic [TW-1:0] elapsed_q;
  logic          waiting;

  assign waiting = acc && !rdy;
  // Fires on the limit-th consecutive access cycle without ready.
  assign fire = waiting && (elapsed_q >= (limit - TW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else if (waiting && !fire) begin
      elapsed_q <= elapsed_q + TW'(1);
    end else begin
      elapsed_q <= '0;
    end
  end
endmodule

// File: rtl/tmo_regs.sv
module tmo_regs
  import tmo_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter int          CAW     = 4,
  parameter logic [31:0] TMO_RST = 32'h400,
  parameter logic [31:0] TMO_MIN = 32'h3FF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_psel,
  input  logic           cfg_penable,
  input  logic           cfg_pwrite,
  input  logic [CAW-1:0] cfg_paddr,
  input  logic [DW-1:0]  cfg_pwdata,
  output logic [DW-1:0]  cfg_prdata,
  input  logic           fire,
  input  logic [AW-1:0]  fault_addr,
  output logic           pend,
  output logic           en,
  output logic [AW-1:0]  cap,
  output logic [31:0]    lim
);
  reg_sel_e sel;
  logic     wr;
  logic     wr_stat;
  logic     wr_lim;

  assign sel     = decode_off({{(32-CAW){1'b0}}, cfg_paddr});
  assign wr      = cfg_psel && cfg_penable && cfg_pwrite;
  assign wr_stat = wr && (sel == SEL_STAT);
  assign wr_lim  = wr && (sel == SEL_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      en   <= 1'b0;
    end else if (wr_stat) begin
      pend <= cfg_pwdata[0] | fire;
      en   <= cfg_pwdata[1];
    end else begin
      pend <= pend | fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0;
    end else if (fire && !pend) begin
      cap <= fault_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim <= TMO_RST;
    end else if (wr_lim) begin
      lim <= clamp_limit(32'(cfg_pwdata), TMO_MIN);
    end
  end

  always_comb begin
    case (sel)
      SEL_STAT: cfg_prdata = DW'({en, pend});
      SEL_ADDR: cfg_prdata = DW'(cap);
      SEL_LIM:  cfg_prdata = DW'(lim);
      default:  cfg_prdata = '0;
    endcase
  end
endmodule

// File: rtl/tmo_resp.sv
module tmo_resp #(
  parameter int DW = 32
) (
  input  logic          fire,
  input  logic          slv_pready,
  input  logic          slv_pslverr,
  input  logic [DW-1:0] slv_prdata,
  output logic          mst_pready,
  output logic          mst_pslverr,
  output logic [DW-1:0] mst_prdata
);
  always_comb begin
    if (fire) begin
      mst_pready  = 1'b1;
      mst_pslverr = 1'b1;
      mst_prdata  = '0;
    end else begin
      mst_pready  = slv_pready;
      mst_pslverr = slv_pslverr;
      mst_prdata  = slv_prdata;
    end
  end
endmodule

// File: rtl/apb_tmo_term.sv
module apb_tmo_term #(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter int          CAW     = 4,
  parameter logic [31:0] TMO_RST = 32'h400,
  parameter logic [31:0] TMO_MIN = 32'h3FF
) (
  input  logic           pclk,
  input  logic           presetn,
  input  logic           mon_psel,
  input  logic           mon_penable,
  input  logic [AW-1:0]  mon_paddr,
  input  logic           slv_pready,
  input  logic           slv_pslverr,
  input  logic [DW-1:0]  slv_prdata,
  output logic           mst_pready,
  output logic           mst_pslverr,
  output logic [DW-1:0]  mst_prdata,
  input  logic           cfg_psel,
  input  logic           cfg_penable,
  input  logic           cfg_pwrite,
  input  logic [CAW-1:0] cfg_paddr,
  input  logic [DW-1:0]  cfg_pwdata,
  output logic [DW-1:0]  cfg_prdata,
  output logic           irq
);
  localparam int TW = 32;

  logic          acc_w;
  logic          fire_w;
  logic          pend_w;
  logic          en_w;
  logic [AW-1:0] cap_w;
  logic [31:0]   lim_w;

  assign acc_w = mon_psel && mon_penable;

  tmo_watch #(.TW(TW)) u_watch (
    .clk   (pclk),
    .rst_n (presetn),
    .acc   (acc_w),
    .rdy   (slv_pready),
    .limit (lim_w),
    .fire  (fire_w)
  );

  tmo_regs #(
    .AW(AW), .DW(DW), .CAW(CAW), .TMO_RST(TMO_RST), .TMO_MIN(TMO_MIN)
  ) u_regs (
    .clk         (pclk),
    .rst_n       (presetn),
    .cfg_psel    (cfg_psel),
    .cfg_penable (cfg_penable),
    .cfg_pwrite  (cfg_pwrite),
    .cfg_paddr   (cfg_paddr),
    .cfg_pwdata  (cfg_pwdata),
    .cfg_prdata  (cfg_prdata),
    .fire        (fire_w),
    .fault_addr  (mon_paddr),
    .pend        (pend_w),
    .en          (en_w),
    .cap         (cap_w),
    .lim         (lim_w)
  );

  tmo_resp #(.DW(DW)) u_resp (
    .fire        (fire_w),
    .slv_pready  (slv_pready),
    .slv_pslverr (slv_pslverr),
    .slv_prdata  (slv_prdata),
    .mst_pready  (mst_pready),
    .mst_pslverr (mst_pslverr),
    .mst_prdata  (mst_prdata)
  );

  assign irq = pend_w && en_w;
endmodule

// File: rtl/tmo_chk.sv
module tmo_chk #(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter logic [31:0] TMO_MIN = 32'h3FF
) (
  input logic          pclk,
  input logic          presetn,
  input logic          mon_psel,
  input logic          mon_penable,
  input logic          slv_pready,
  input logic          slv_pslverr,
  input logic          mst_pready,
  input logic          mst_pslverr,
  input logic [DW-1:0] mst_prdata,
  input logic          fire_w,
  input logic          pend_w,
  input logic          en_w,
  input logic [AW-1:0] cap_w,
  input logic [31:0]   lim_w,
  input logic          irq
);
  AST_FORCED_RESP: assert property (@(posedge pclk) disable iff (!presetn)
    fire_w |-> (mst_pready && mst_pslverr && (mst_prdata == '0))); // R5
  AST_PASS_THRU: assert property (@(posedge pclk) disable iff (!presetn)
    !fire_w |-> ((mst_pready == slv_pready) && (mst_pslverr == slv_pslverr))); // R4
  AST_NO_FIRE_ON_READY: assert property (@(posedge pclk) disable iff (!presetn)
    slv_pready |-> !fire_w); // R4
  AST_FIRE_IN_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    fire_w |-> (mon_psel && mon_penable)); // R10
  AST_PEND_AFTER_FIRE: assert property (@(posedge pclk) disable iff (!presetn)
    fire_w |=> pend_w); // R6
  AST_ADDR_KEEP: assert property (@(posedge pclk) disable iff (!presetn)
    pend_w |=> $stable(cap_w)); // R7
  AST_LIM_FLOOR: assert property (@(posedge pclk) disable iff (!presetn)
    lim_w >= TMO_MIN); // R3
  AST_IRQ_NEEDS_EN: assert property (@(posedge pclk) disable iff (!presetn)
    irq |-> (en_w && pend_w)); // R8
endmodule

bind apb_tmo_term tmo_chk #(.AW(AW), .DW(DW), .TMO_MIN(TMO_MIN)) u_chk (
  .pclk        (pclk),
  .presetn     (presetn),
  .mon_psel    (mon_psel),
  .mon_penable (mon_penable),
  .slv_pready  (slv_pready),
  .slv_pslverr (slv_pslverr),
  .mst_pready  (mst_pready),
  .mst_pslverr (mst_pslverr),
  .mst_prdata  (mst_prdata),
  .fire_w      (fire_w),
  .pend_w      (pend_w),
  .en_w        (en_w),
  .cap_w       (cap_w),
  .lim_w       (lim_w),
  .irq         (irq)
);

// File: tb/sim_apb_tmo_term.sv
`timescale 1ns/1ps
module sim_apb_tmo_term;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int CAW = 4;

  logic          pclk = 1'b0;
  logic          presetn = 1'b0;
  logic          mon_psel = 1'b0, mon_penable = 1'b0;
  logic [AW-1:0] mon_paddr = '0;
  logic          slv_pready = 1'b0, slv_pslverr = 1'b0;
  logic [DW-1:0] slv_prdata = '0;
  logic          mst_pready, mst_pslverr;
  logic [DW-1:0] mst_prdata;
  logic          cfg_psel = 1'b0, cfg_penable = 1'b0, cfg_pwrite = 1'b0;
  logic [CAW-1:0] cfg_paddr = '0;
  logic [DW-1:0] cfg_pwdata = '0;
  logic [DW-1:0] cfg_prdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic        m_pend = 1'b0, m_en = 1'b0;
  logic [31:0] m_addr = '0, m_lim = 32'h400;

  always #2 pclk = ~pclk;

  apb_tmo_term u0 (
    .pclk(pclk), .presetn(presetn),
    .mon_psel(mon_psel), .mon_penable(mon_penable), .mon_paddr(mon_paddr),
    .slv_pready(slv_pready), .slv_pslverr(slv_pslverr), .slv_prdata(slv_prdata),
    .mst_pready(mst_pready), .mst_pslverr(mst_pslverr), .mst_prdata(mst_prdata),
    .cfg_psel(cfg_psel), .cfg_penable(cfg_penable), .cfg_pwrite(cfg_pwrite),
    .cfg_paddr(cfg_paddr), .cfg_pwdata(cfg_pwdata), .cfg_prdata(cfg_prdata),
    .irq(irq)
  );

  function automatic logic [31:0] floor_of(input logic [31:0] v);
    return (v > 32'h3FE) ? v : 32'h3FF;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge pclk);
    cfg_psel = 1'b1; cfg_pwrite = 1'b1; cfg_paddr = a; cfg_pwdata = d; cfg_penable = 1'b0;
    @(negedge pclk);
    cfg_penable = 1'b1;
    @(negedge pclk);
    cfg_psel = 1'b0; cfg_penable = 1'b0; cfg_pwrite = 1'b0;
  endtask

  task automatic cfg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge pclk);
    cfg_psel = 1'b1; cfg_pwrite = 1'b0; cfg_paddr = a; cfg_penable = 1'b0;
    @(negedge pclk);
    cfg_penable = 1'b1;
    #1 d = cfg_prdata;
    @(negedge pclk);
    cfg_psel = 1'b0; cfg_penable = 1'b0;
  endtask

  task automatic stat_wr(input logic [1:0] v);
    cfg_wr(4'h0, {30'd0, v});
    m_pend = v[0];
    m_en   = v[1];
  endtask

  task automatic regs_vs_model(input string req);
    logic [31:0] d;
    cfg_rd(4'h0, d); chk({req, " status"}, d, {30'd0, m_en, m_pend});
    cfg_rd(4'h4, d); chk({req, " address"}, d, m_addr);
    cfg_rd(4'h8, d); chk({req, " limit"}, d, m_lim);
    chk({req, " irq"}, {31'd0, irq}, {31'd0, m_pend & m_en});
  endtask

  // Monitored transfer whose slave answers on access cycle r (0 = never).
  task automatic mon_xfer(input logic [31:0] a, input int r, input string req);
    int          done_k = 0;
    logic        forced = 1'b0;
    logic [31:0] rd = '0;
    logic [31:0] pat = '0;
    logic        perr = 1'b0;
    int          exp_k;
    logic        exp_forced;
    @(negedge pclk);
    mon_psel = 1'b1; mon_penable = 1'b0; mon_paddr = a; slv_pready = 1'b0;
    @(negedge pclk);
    mon_penable = 1'b1;
    for (int k = 1; k <= 5000; k++) begin
      slv_pready = (k == r);
      if (k == r) begin
        pat = $urandom; perr = 1'($urandom % 2);
        slv_prdata = pat; slv_pslverr = perr;
      end
      #1;
      if (mst_pready) begin
        done_k = k; forced = mst_pslverr; rd = mst_prdata;
        break;
      end
      @(negedge pclk);
    end
    @(negedge pclk);
    mon_psel = 1'b0; mon_penable = 1'b0; slv_pready = 1'b0; slv_pslverr = 1'b0;
    exp_forced = !((r >= 1) && (r <= int'(m_lim)));
    exp_k = exp_forced ? int'(m_lim) : r;
    chk({req, " completion cycle"}, 32'(done_k), 32'(exp_k));
    if (exp_forced) begin
      chk({req, " R5 forced error"}, {31'd0, forced}, 32'd1);
      chk({req, " R5 forced data"}, rd, 32'd0);
      if (!m_pend) m_addr = a;
      m_pend = 1'b1;
    end else begin
      chk({req, " R4 passed error"}, {31'd0, forced}, {31'd0, perr});
      chk({req, " R4 passed data"}, rd, pat);
    end
  endtask

  always @(posedge pclk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    // R1 reset state
    regs_vs_model("R1");
    // R2 unmapped offset reads zero and ignores writes
    cfg_wr(4'hC, 32'hFFFF_FFFF);
    cfg_rd(4'hC, d); chk("R2 unmapped read", d, 32'd0);
    regs_vs_model("R2");
    // R3 limit clamping
    cfg_wr(4'h8, 32'h500); m_lim = floor_of(32'h500); regs_vs_model("R3 large");
    cfg_wr(4'h8, 32'h3FF); m_lim = floor_of(32'h3FF); regs_vs_model("R3 floor");
    cfg_wr(4'h8, 32'h5);   m_lim = floor_of(32'h5);   regs_vs_model("R3 small");
    // R4 immediate answer and answer on the last allowed cycle
    mon_xfer(32'h1000_0004, 1, "R4 first cycle");
    mon_xfer(32'h1000_0008, int'(m_lim), "R4 last cycle");
    regs_vs_model("R4 no fault");
    // R5 R6 slave one cycle late
    mon_xfer(32'h1D00_0010, int'(m_lim) + 1, "R5 late");
    regs_vs_model("R6 capture");
    // R8 enable the interrupt
    stat_wr(2'b11); regs_vs_model("R8 irq high");
    // R7 second fault keeps first address
    mon_xfer(32'h1D00_0FF0, 0, "R7 second fault");
    regs_vs_model("R7 keep");
    // R9 clear then inject
    stat_wr(2'b10); regs_vs_model("R9 clear");
    stat_wr(2'b11); regs_vs_model("R9 inject");
    stat_wr(2'b00); regs_vs_model("R9 off");
    // R10 back-to-back transfers each at the window edge
    mon_xfer(32'h1200_0000, int'(m_lim), "R10 first");
    mon_xfer(32'h1200_0004, int'(m_lim), "R10 second");
    regs_vs_model("R10 no fault");
    // Random mix
    for (int i = 0; i < 16; i++) begin
      logic [31:0] a;
      int r;
      a = $urandom & 32'hFFFF_FFFC;
      if ($urandom % 2) r = 1 + int'($urandom % 4);
      else r = int'(m_lim) - 2 + int'($urandom % 5);
      mon_xfer(a, r, "R4/R5 random");
      if ($urandom % 3 == 0) stat_wr(2'($urandom % 4));
      regs_vs_model("R6/R7/R9 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule